// File: doc/BRIEF.md
# Double-Buffered Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. The line rests high. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. An external strobe marks sixteen sample points per bit. The receiver confirms the start bit halfway through it. It then samples every bit at its centre, removes the framing bits and builds the byte in a shift register.

A finished byte moves at once into a separate holding register. The shift register can then take in the next frame while the consumer has not yet collected the held byte. The held byte is offered on a valid/ready output. The line itself cannot be stalled, so back-pressure can only delay the collection. If the consumer is still holding off when the next byte completes, the new byte replaces the old one and an overrun flag marks it. Each byte also carries a framing-error flag. A modem-ready input is synchronised and reported as a plain status pin.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset `rx_valid_o`, `frame_err_o` and `overrun_o` are 0. A frame begins only when the synchronised line is found low at an oversample strobe while the receiver is idle.
- R2: Each bit lasts 16 strobes. The start bit is confirmed at the 8th strobe after detection. Each data bit and the stop bit are sampled 16 strobes after the previous sample. The first data bit received becomes bit 0 of `rx_data_o`. The start and stop bits are not delivered.
- R3: A stop bit sampled as 0 still delivers the byte, with `frame_err_o` = 1. `frame_err_o` is 0 for a byte whose stop bit was 1.
- R4: If the line is high again at the start-confirmation sample, the low pulse is discarded and no byte is produced.
- R5: If a byte completes while the held byte is valid and not being taken in that cycle, the new byte replaces it and `overrun_o` = 1.
- R6: A byte stays on `rx_data_o` with `rx_valid_o` = 1, unchanged, until a clock edge with `rx_ready_i` = 1. Unless a new byte loads at that edge, `rx_valid_o`, `frame_err_o` and `overrun_o` are 0 one cycle later.
- R7: If a handshake and a byte load fall on the same edge, the new byte is held with `rx_valid_o` = 1 and `overrun_o` = 0.
- R8: A second frame is received correctly while the first byte is still held and unread.
- R9: `dsr_o` follows `dsr_i` through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | Oversample strobe, 16 per bit time |
| dsr_i | input | 1 | Modem-ready input |
| rx_data_o | output | 8 | Held byte |
| rx_valid_o | output | 1 | Held byte is valid |
| rx_ready_i | input | 1 | Consumer takes the held byte |
| frame_err_o | output | 1 | Held byte had a low stop bit |
| overrun_o | output | 1 | Held byte replaced an unread byte |
| dsr_o | output | 1 | Synchronised modem-ready status |

## Verification
A consumer handshake and the load of a newly completed byte can land on the same clock edge. When they do, the load must win and no overrun may be raised, because the old byte was taken. The bench first measures the delay from the start of a stop bit to `rx_valid_o` rising. It then sends a second frame with the first byte still held, and raises `rx_ready_i` for exactly the one cycle whose edge performs the load. It judges the result from the held data, `rx_valid_o` and `overrun_o`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OVS_DEF   = 16;
  localparam int unsigned DW_DEF    = 8;
  localparam int unsigned SYNC_DEF  = 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES    = uart_rx_pkg::SYNC_DEF,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RESET_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = OVS_DEF,
  parameter int unsigned DW  = DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick_i,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          stop_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned BW  = $clog2(DW + 1);
  localparam logic [CW-1:0] MID_M1  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_B  = BW'(DW - 1);

  rx_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [BW-1:0]   bit_q;
  logic [DW-1:0]   shift_q;
  logic            done_q;
  logic            stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) state_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == MID_M1) begin
              cnt_q <= '0;
              bit_q <= '0;
              state_q <= rx_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              shift_q <= {rx_i, shift_q[DW-1:1]};
              if (bit_q == LAST_B) state_q <= RX_STOP;
              else                 bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              stop_q  <= rx_i;
              done_q  <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign byte_o = shift_q;
  assign stop_o = stop_q;

  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && $past(state_q) == RX_IDLE) |-> !$past(rx_i)); // R1
  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && $past(state_q) == RX_START) |-> $past(rx_i)); // R4
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state_q) == RX_STOP && state_q == RX_IDLE)); // R2
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int unsigned DW = uart_rx_pkg::DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  input  logic          stop_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output logic          ovr_o
);
  logic          valid_q, ferr_q, ovr_q;
  logic [DW-1:0] data_q;
  logic          take;

  assign take = valid_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= byte_i;
      ferr_q  <= !stop_i;
      ovr_q   <= valid_q && !take;
    end else if (take) begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign ferr_o  = ferr_q;
  assign ovr_o   = ovr_q;

  AST_FERR_TRACKS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ferr_q == !$past(stop_i))); // R3
  AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && valid_q && !ready_i) |=> ovr_q); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i && !load_i) |=> (valid_q && $stable(data_q))); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready_i && !load_i) |=> (!valid_q && !ovr_q)); // R6
  AST_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ready_i && load_i) |=> (valid_q && !ovr_q)); // R7
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS  = OVS_DEF,
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned SYNC = SYNC_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_i,
  input  logic          os_tick_i,
  input  logic          dsr_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  output logic          frame_err_o,
  output logic          overrun_o,
  output logic          dsr_o
);
  logic          rx_s;
  logic          done;
  logic [DW-1:0] shifted;
  logic          stop_bit;

  rx_sync #(.STAGES(SYNC), .RESET_VAL(1'b1)) i_rx_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rxd_i), .sync_o(rx_s));

  rx_sync #(.STAGES(SYNC), .RESET_VAL(1'b0)) i_dsr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(dsr_i), .sync_o(dsr_o));

  rx_frame #(.OVS(OVS), .DW(DW)) i_frame (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_s), .tick_i(os_tick_i),
    .done_o(done), .byte_o(shifted), .stop_o(stop_bit));

  rx_hold #(.DW(DW)) i_hold (
    .clk(clk), .rst_n(rst_n), .load_i(done), .byte_i(shifted),
    .stop_i(stop_bit), .ready_i(rx_ready_i), .valid_o(rx_valid_o),
    .data_o(rx_data_o), .ferr_o(frame_err_o), .ovr_o(overrun_o));
endmodule

// File: tb/test_uart_rx_dbuf.sv
`timescale 1ns/1ps
module test_uart_rx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       dsr = 1'b0;
  logic       ready = 1'b0;
  logic [7:0] data;
  logic       valid, ferr, ovr, dsr_s;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int stop_t = 0;
  int lat_k = 0;
  bit stop_flag = 1'b0;
  bit done = 1'b0;
  int tcnt = 0;

  always #2.5 clk = ~clk;

  uart_rx_dbuf i_uart_rx_dbuf (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick), .dsr_i(dsr),
    .rx_data_o(data), .rx_valid_o(valid), .rx_ready_i(ready),
    .frame_err_o(ferr), .overrun_o(ovr), .dsr_o(dsr_s));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 2);
  end

  always @(negedge clk) begin
    if (!done && cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stop, input int stop_len);
    stop_flag = 1'b0;
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_ticks(16);
    end
    rxd = stop;
    stop_t = cyc;
    stop_flag = 1'b1;
    wait_ticks(stop_len);
    rxd = 1'b1;
    wait_ticks(4);
  endtask

  task automatic take_byte(input string req);
    @(negedge clk) ready = 1'b1;
    @(negedge clk) ready = 1'b0;
    chk(req, valid, 0);
    chk(req, ovr, 0);
    chk(req, ferr, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", valid, 0);
    chk("R1 reset ferr", ferr, 0);
    chk("R1 reset ovr", ovr, 0);
  endtask

  task automatic t_basic;
    fork
      send_frame(8'hA5, 1'b1, 16);
      begin
        wait (stop_flag);
        while (!valid) @(negedge clk);
        lat_k = cyc - stop_t;
      end
    join
    chk("R2 data A5", data, 8'hA5);
    chk("R1 valid", valid, 1);
    chk("R3 ferr clean", ferr, 0);
    repeat (20) @(negedge clk);
    chk("R6 hold stable", data, 8'hA5);
    chk("R6 hold valid", valid, 1);
    take_byte("R6 read clears");
  endtask

  task automatic t_patterns;
    logic [7:0] pats [3] = '{8'h00, 8'hFF, 8'h3C};
    foreach (pats[i]) begin
      send_frame(pats[i], 1'b1, 16);
      chk("R2 pattern", data, pats[i]);
      chk("R2 pattern valid", valid, 1);
      take_byte("R6 pattern read");
    end
  endtask

  task automatic t_glitch;
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(200);
    chk("R4 glitch no byte", valid, 0);
    send_frame(8'h5A, 1'b1, 16);
    chk("R4 after glitch", data, 8'h5A);
    take_byte("R4 read");
  endtask

  task automatic t_framing;
    send_frame(8'hC3, 1'b0, 12);
    wait_ticks(20);
    chk("R3 ferr set", ferr, 1);
    chk("R3 data kept", data, 8'hC3);
    chk("R3 valid", valid, 1);
    take_byte("R3 read clears ferr");
    wait_ticks(200);
    chk("R4 no stray byte", valid, 0);
  endtask

  task automatic t_overrun;
    send_frame(8'h81, 1'b1, 16);
    chk("R5 first no ovr", ovr, 0);
    send_frame(8'h7E, 1'b1, 16);
    chk("R8 second byte", data, 8'h7E);
    chk("R5 ovr set", ovr, 1);
    chk("R5 valid", valid, 1);
    take_byte("R5 read clears ovr");
  endtask

  task automatic t_same_edge;
    send_frame(8'h11, 1'b1, 16);
    chk("R7 first held", data, 8'h11);
    fork
      send_frame(8'h22, 1'b1, 16);
      begin
        wait (stop_flag);
        while (cyc != stop_t + lat_k - 1) @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        chk("R7 same edge valid", valid, 1);
        chk("R7 same edge data", data, 8'h22);
        chk("R7 same edge no ovr", ovr, 0);
      end
    join
    take_byte("R7 read");
  endtask

  task automatic t_dsr;
    @(negedge clk) dsr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 dsr high", dsr_s, 1);
    dsr = 1'b0;
    @(negedge clk);
    chk("R9 dsr sync delay", dsr_s, 1);
    @(negedge clk);
    chk("R9 dsr low", dsr_s, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_patterns();
    t_glitch();
    t_framing();
    t_overrun();
    t_same_edge();
    t_dsr();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule